// File: doc/BRIEF.md
# Floppy Controller Output Control Register

This block holds the host-visible control byte of a two-drive floppy disk controller, together with a companion byte that assigns tape support and carries a boot-drive swap flag. The host writes both bytes over a small I/O register bus. The control byte drives the active-low motor-on and drive-select lines. It opens or closes the controller's DMA and interrupt paths to the pins. It also holds an active-low software reset for the controller core and its FIFO.

The swap flag changes which physical motor and select line each logical bit drives. Without changing any other setting, this lets the host boot from the second drive. While the DMA gate is closed, the request and interrupt pins are not driven. The acknowledge and terminal-count inputs are then hidden from the controller core, but the raw terminal count stays visible to other units on the chip. After the host releases the software reset, a counter keeps the core reset asserted for a minimum time measured in clock cycles. The reset therefore lasts long enough even when the host clears and sets the bit on consecutive writes.

Top module: `fdc_dout_reg`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both bytes are 0x00, `motor_n` is 2'b11, `drv_sel_n` is 2'b10, `core_rst` is 1, and both pin output enables are 0.
- R2: A write with `bus_addr`=2 stores all eight data bits in the control byte. A read at offset 2 returns that byte, including bits 7, 6 and 1 as written, with `bus_rdata_en`=8'hFF.
- R3: When swap bit 2 of the tape byte is 0, control bit 4 drives `motor_n[0]` and bit 5 drives `motor_n[1]`. Each motor output is low while its bit is 1. When the swap bit is 1, bit 4 drives `motor_n[1]` and bit 5 drives `motor_n[0]`.
- R4: Exactly one bit of `drv_sel_n` is low. When control bit 0 is 0, `drv_sel_n[0]` is low, and when it is 1, `drv_sel_n[1]` is low. Swap bit 2 of the tape byte exchanges the two lines.
- R5: Control bits 7, 6 and 1 have no effect on any output.
- R6: With control bit 3 set, `pin_dreq`/`pin_irq` follow `core_dreq`/`core_irq` with their enables at 1, and `core_dack`/`core_tc` follow `pin_dack`/`pin_tc`. With bit 3 clear, both enables are 0 and `core_dack` and `core_tc` are 0.
- R7: `shared_tc` equals `pin_tc` at all times, whatever the gate setting.
- R8: Control bit 2 is an active-low software reset. `core_rst` is 1 while that bit is 0. After the write that sets the bit to 1, `core_rst` stays 1 for exactly RST_CYCLES more cycles, even when the bit was 0 for a single cycle.
- R9: A software reset (bit 2 at 0) leaves the other control bits and the tape byte unchanged.
- R10: A write with `bus_addr`=3 stores the tape byte, and only `rst` clears it. A read at offset 3 always drives bits 1:0, and drives bits 7:2 only when `ext_reg_en` is 1.
- R11: Writes to any other offset change nothing. Reads at any other offset, and any cycle without `bus_rd`, give `bus_rdata_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rdata_en | output | 8 | Per-bit drive enable for read data |
| ext_reg_en | input | 1 | Exposes tape byte bits 7:2 on reads |
| motor_n | output | 2 | Motor-on lines, active low |
| drv_sel_n | output | 2 | Drive-select lines, active low |
| core_rst | output | 1 | Stretched reset to controller core and FIFO |
| core_dreq | input | 1 | DMA request from the core |
| core_irq | input | 1 | Interrupt from the core |
| pin_dreq | output | 1 | DMA request pin value |
| pin_dreq_oe | output | 1 | Drive enable for pin_dreq |
| pin_irq | output | 1 | Interrupt pin value |
| pin_irq_oe | output | 1 | Drive enable for pin_irq |
| pin_dack | input | 1 | DMA acknowledge from the pin |
| pin_tc | input | 1 | Terminal count from the pin |
| core_dack | output | 1 | Gated acknowledge to the core |
| core_tc | output | 1 | Gated terminal count to the core |
| shared_tc | output | 1 | Ungated terminal count for other units |

## Verification
Two events can fall in the same cycle. A write that opens or closes the DMA gate can land in a cycle where the acknowledge and terminal-count pins are active. To provoke this, the bench drives those pins, and the core request and interrupt, with fresh random values on every cycle while it toggles the gate bit. The reference model judges each cycle by the gate value that holds after the write's clock edge. The same collision is forced between a release of the software reset and a still-running stretch count: the bench clears and sets the reset bit on back-to-back writes, then counts how many cycles `core_rst` stays high after the releasing edge.

// File: rtl/fdo_pkg.sv
package fdo_pkg;

    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 3'd2;
    localparam logic [ADDR_W-1:0] TAPE_OFS = 3'd3;
    localparam int SWAP_BIT  = 2;
    localparam int TAPE_LOW_W = 2;

    typedef struct packed {
        logic [1:0] spare_hi;
        logic       mot1;
        logic       mot0;
        logic       dma_en;
        logic       run;
        logic       spare_lo;
        logic       drv;
    } ctrl_t;

    function automatic logic [1:0] pair_swap(input logic [1:0] v, input logic sw);
        return sw ? {v[0], v[1]} : v;
    endfunction

endpackage

// File: rtl/fdo_regs.sv
module fdo_regs
    import fdo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_en,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] rdata_en,
    output logic [1:0]        mot,
    output logic              dma_en,
    output logic              run,
    output logic              drv,
    output logic              swap
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] tape_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tape_q <= '0;
        end else if (wr) begin
            if (addr == CTRL_OFS) ctrl_q <= ctrl_t'(wdata);
            if (addr == TAPE_OFS) tape_q <= wdata;
        end
    end

    always_comb begin
        rdata    = '0;
        rdata_en = '0;
        if (rd) begin
            if (addr == CTRL_OFS) begin
                rdata    = ctrl_q;
                rdata_en = '1;
            end else if (addr == TAPE_OFS) begin
                rdata    = tape_q;
                rdata_en = {{(DATA_W-TAPE_LOW_W){ext_en}}, {TAPE_LOW_W{1'b1}}};
            end
        end
    end

    assign mot    = {ctrl_q.mot1, ctrl_q.mot0};
    assign dma_en = ctrl_q.dma_en;
    assign run    = ctrl_q.run;
    assign drv    = ctrl_q.drv;
    assign swap   = tape_q[SWAP_BIT];

endmodule

// File: rtl/fdo_drive_map.sv
module fdo_drive_map
    import fdo_pkg::*;
#(
    parameter int NUM_LINES = 2
) (
    input  logic [NUM_LINES-1:0] mot,
    input  logic                 drv,
    input  logic                 swap,
    output logic [NUM_LINES-1:0] motor_n,
    output logic [NUM_LINES-1:0] sel_n
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam logic PHYS = i[0];
        logic src;
        assign src        = PHYS ^ swap;
        assign motor_n[i] = ~mot[src];
        assign sel_n[i]   = ~(drv == src);
    end

endmodule

// File: rtl/fdo_rst_stretch.sv
module fdo_rst_stretch #(
    parameter int RST_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic core_rst
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || !run)          remain_q <= LOAD;
        else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
    end

    assign core_rst = !run || (remain_q != '0);

endmodule

// File: rtl/fdo_dma_gate.sv
module fdo_dma_gate (
    input  logic gate,
    input  logic core_dreq,
    input  logic core_irq,
    input  logic pin_dack,
    input  logic pin_tc,
    output logic pin_dreq,
    output logic pin_dreq_oe,
    output logic pin_irq,
    output logic pin_irq_oe,
    output logic core_dack,
    output logic core_tc,
    output logic shared_tc
);
    assign pin_dreq    = core_dreq;
    assign pin_irq     = core_irq;
    assign pin_dreq_oe = gate;
    assign pin_irq_oe  = gate;
    assign core_dack   = pin_dack & gate;
    assign core_tc     = pin_tc & gate;
    assign shared_tc   = pin_tc;

endmodule

// File: rtl/fdc_dout_reg.sv
module fdc_dout_reg
    import fdo_pkg::*;
#(
    parameter int RST_CYCLES = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [7:0]  bus_rdata_en,
    input  logic        ext_reg_en,
    output logic [1:0]  motor_n,
    output logic [1:0]  drv_sel_n,
    output logic        core_rst,
    input  logic        core_dreq,
    input  logic        core_irq,
    output logic        pin_dreq,
    output logic        pin_dreq_oe,
    output logic        pin_irq,
    output logic        pin_irq_oe,
    input  logic        pin_dack,
    input  logic        pin_tc,
    output logic        core_dack,
    output logic        core_tc,
    output logic        shared_tc
);
    logic [1:0] mot_bits;
    logic       dma_open;
    logic       dor_run;
    logic       drv_bit;
    logic       boot_sel;

    fdo_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .ext_en   (ext_reg_en),
        .rdata    (bus_rdata),
        .rdata_en (bus_rdata_en),
        .mot      (mot_bits),
        .dma_en   (dma_open),
        .run      (dor_run),
        .drv      (drv_bit),
        .swap     (boot_sel)
    );

    fdo_drive_map #(.NUM_LINES(2)) u_map (
        .mot     (mot_bits),
        .drv     (drv_bit),
        .swap    (boot_sel),
        .motor_n (motor_n),
        .sel_n   (drv_sel_n)
    );

    fdo_rst_stretch #(.RST_CYCLES(RST_CYCLES)) u_stretch (
        .clk      (clk),
        .rst      (rst),
        .run      (dor_run),
        .core_rst (core_rst)
    );

    fdo_dma_gate u_gate (
        .gate        (dma_open),
        .core_dreq   (core_dreq),
        .core_irq    (core_irq),
        .pin_dack    (pin_dack),
        .pin_tc      (pin_tc),
        .pin_dreq    (pin_dreq),
        .pin_dreq_oe (pin_dreq_oe),
        .pin_irq     (pin_irq),
        .pin_irq_oe  (pin_irq_oe),
        .core_dack   (core_dack),
        .core_tc     (core_tc),
        .shared_tc   (shared_tc)
    );

endmodule

// File: rtl/fdo_checker.sv
module fdo_checker
    import fdo_pkg::*;
#(
    parameter int RST_CYCLES = 50000
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  bus_addr,
    input logic        bus_wr,
    input logic [1:0]  wr_mot,
    input logic [1:0]  motor_n,
    input logic [1:0]  drv_sel_n,
    input logic        core_rst,
    input logic        run,
    input logic        boot,
    input logic        pin_dreq_oe,
    input logic        pin_irq_oe,
    input logic        core_dack,
    input logic        core_tc,
    input logic        pin_tc,
    input logic        shared_tc
);
    localparam int HW = $clog2(RST_CYCLES + 2);
    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)   hold_cnt <= '0;
        else if (core_rst) hold_cnt <= hold_cnt + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (motor_n == 2'b11 && drv_sel_n == 2'b10 && core_rst && !pin_dreq_oe && !pin_irq_oe));

    assert_motor_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CTRL_OFS) |=> (motor_n == ~pair_swap($past(wr_mot), boot)));

    assert_one_select_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(drv_sel_n) == 1);

    assert_gate_mask_R6: assert property (@(posedge clk) disable iff (rst)
        !pin_dreq_oe |-> (!core_dack && !core_tc && !pin_irq_oe));

    assert_tc_pass_R7: assert property (@(posedge clk) disable iff (rst)
        shared_tc == pin_tc);

    assert_held_low_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> core_rst);

    assert_stretch_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (hold_cnt == HW'(RST_CYCLES)));

endmodule

bind fdc_dout_reg fdo_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .wr_mot      (bus_wdata[5:4]),
    .motor_n     (motor_n),
    .drv_sel_n   (drv_sel_n),
    .core_rst    (core_rst),
    .run         (dor_run),
    .boot        (boot_sel),
    .pin_dreq_oe (pin_dreq_oe),
    .pin_irq_oe  (pin_irq_oe),
    .core_dack   (core_dack),
    .core_tc     (core_tc),
    .pin_tc      (pin_tc),
    .shared_tc   (shared_tc)
);

// File: tb/fdc_dout_reg_bench.sv
module fdc_dout_reg_bench;

    localparam int N = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, bus_rdata_en;
    logic       ext_reg_en = 1'b0;
    logic [1:0] motor_n, drv_sel_n;
    logic       core_rst;
    logic       core_dreq = 1'b0, core_irq = 1'b0, pin_dack = 1'b0, pin_tc = 1'b0;
    logic       pin_dreq, pin_dreq_oe, pin_irq, pin_irq_oe;
    logic       core_dack, core_tc, shared_tc;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fdc_dout_reg #(.RST_CYCLES(N)) u_fdc_dout_reg (
        .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata, .bus_rdata_en,
        .ext_reg_en, .motor_n, .drv_sel_n, .core_rst, .core_dreq, .core_irq,
        .pin_dreq, .pin_dreq_oe, .pin_irq, .pin_irq_oe, .pin_dack, .pin_tc,
        .core_dack, .core_tc, .shared_tc
    );

    // reference model state
    logic [7:0] m_ctrl = '0;
    logic [7:0] m_tape = '0;
    int         m_left = N;

    always @(posedge clk) begin
        bit was_run;
        started = 1;
        was_run = m_ctrl[2];
        if (rst) begin
            m_ctrl = '0;
            m_tape = '0;
            m_left = N;
        end else begin
            if (bus_wr && bus_addr == 3'd2) m_ctrl = bus_wdata;
            if (bus_wr && bus_addr == 3'd3) m_tape = bus_wdata;
            if (!was_run)       m_left = N;
            else if (m_left > 0) m_left = m_left - 1;
        end
    end

    // random handshake activity every cycle
    always @(posedge clk) begin
        #2;
        core_dreq = 1'($urandom);
        core_irq  = 1'($urandom);
        pin_dack  = 1'($urandom);
        pin_tc    = 1'($urandom);
    end

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            logic       sw;
            logic [1:0] mt;
            logic       phys;
            logic       gate;
            logic [7:0] en;
            sw   = m_tape[2];
            mt   = {m_ctrl[5], m_ctrl[4]};
            if (sw) mt = {mt[0], mt[1]};
            phys = m_ctrl[0] ^ sw;
            gate = m_ctrl[3];
            check_eq("R3 R5 motor", {6'd0, motor_n}, {6'd0, ~mt});
            check_eq("R4 R5 select", {6'd0, drv_sel_n}, phys ? 8'h01 : 8'h02);
            check_eq("R8 core reset", {7'd0, core_rst}, {7'd0, (!m_ctrl[2] || m_left > 0)});
            check_eq("R6 gate", {2'd0, pin_dreq_oe, pin_irq_oe, pin_dreq, pin_irq, core_dack, core_tc},
                     {2'd0, gate, gate, core_dreq, core_irq, pin_dack & gate, pin_tc & gate});
            check_eq("R7 shared tc", {7'd0, shared_tc}, {7'd0, pin_tc});
            if (bus_rd && bus_addr == 3'd2) begin
                check_eq("R2 read en", bus_rdata_en, 8'hFF);
                check_eq("R2 read data", bus_rdata, m_ctrl);
            end else if (bus_rd && bus_addr == 3'd3) begin
                en = ext_reg_en ? 8'hFF : 8'h03;
                check_eq("R10 read en", bus_rdata_en, en);
                check_eq("R10 read data", bus_rdata & en, m_tape & en);
            end else begin
                check_eq("R11 no drive", bus_rdata_en, 8'h00);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        check_eq(tag, bus_rdata, exp);
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        @(posedge clk); #2;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 reset outputs", {motor_n, drv_sel_n, core_rst, pin_dreq_oe, 2'b00}, 8'b11_10_1_0_00);
        @(posedge clk); #2;
        idle(2);
        wr(3'd2, 8'h04);               // release, R8 stretch
        idle(N + 4);
        wr(3'd2, 8'h3D);               // both motors, gate, drive 1
        idle(4);
        rd(3'd2);
        wr(3'd2, 8'h1C);               // motor 0, drive 0
        idle(3);
        wr(3'd2, 8'h14);               // gate closed mid-traffic, R6
        idle(5);
        wr(3'd2, 8'h1C);
        wr(3'd3, 8'h04);               // swap on
        idle(3);
        ext_reg_en = 1'b0;
        rd(3'd3);
        ext_reg_en = 1'b1;
        rd(3'd3);
        wr(3'd2, 8'h2D);
        idle(3);
        wr(3'd2, 8'hEE);               // reserved bits set, R5
        @(negedge clk);
        check_eq("R5 motor with reserved bits", {6'd0, motor_n}, 8'h02);
        check_eq("R5 select with reserved bits", {6'd0, drv_sel_n}, 8'h01);
        @(posedge clk); #2;
        rd_chk(3'd2, 8'hEE, "R2 reserved bits read back");
        wr(3'd2, 8'h28);               // software reset with other bits kept, R9
        rd_chk(3'd2, 8'h28, "R9 control kept in soft reset");
        rd_chk(3'd3, 8'h04, "R9 tape kept in soft reset");
        wr(3'd2, 8'h2C);
        idle(N + 3);
        wr(3'd2, 8'h28);               // back-to-back toggle, R8
        wr(3'd2, 8'h2C);
        idle(N + 3);
        wr(3'd5, 8'hFF);               // R11 stray write
        idle(2);
        rd(3'd5);
        rd_chk(3'd2, 8'h2C, "R11 control unchanged");
        rd_chk(3'd3, 8'h04, "R11 tape unchanged");
        wr(3'd2, 8'h24);
        idle(6);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd_chk(3'd3, 8'h00, "R10 tape cleared by hard reset");
        rd_chk(3'd2, 8'h00, "R1 control cleared by hard reset");
        idle(3);
        finish_run();
    end

endmodule